// File: doc/BRIEF.md
# Slave-Parallel FPGA Configuration Loader

This block is the master side of a byte-wide configuration link to a target FPGA. A user command selects either a load or a readback and carries a byte count. For a load, the block resets the target with a program pulse and waits until the target reports it is ready. It then raises write-enable, raises select, and clocks one byte from the input stream into the target on each rising edge of the configuration clock. When the last byte has gone, it drops select, then write-enable, and keeps clocking until the target reports that it is configured. For a readback, it raises select with write-enable low and its data driver off. It then gives one clock pulse per byte, returns the byte seen after each rising edge on the output stream, and ends with one extra clock pulse after select is released.

The target's stall line can hold a byte on the bus while the clock keeps toggling. This is enabled at build time. Every wait has a cycle timeout. When a wait expires, the target gets a fresh program pulse, the link lines are released, and a status code names the wait that failed. All target-side lines are active-high at this boundary. The status code is 0 for success, 1 for a ready timeout, 2 for a stall timeout and 3 for a configured timeout.

Top module: `pcfg_loader`

## Requirements
- R1: After reset the program, select, write-enable and data-drive outputs are low and the configuration clock is high. `st_busy` is 0, `st_code` is 0 and `xfer_count` is 0.
- R2: A load drives `tgt_rst` high for exactly PULSE_CYC cycles. Write-enable does not rise until the target shows ready high and stall low. If that does not happen within TIMEOUT_CYC cycles, the load aborts with code 1.
- R3: Write-enable rises before select. Data is driven only while both are high. At the end select falls before write-enable.
- R4: Each load byte is placed on the bus, the clock is taken low, then high. The bus does not change across the rising edge. The target receives the bytes in stream order, one per rise, with no extra bytes.
- R5: With BUSY_CHECK set, a stall seen after a rising edge makes the clock toggle with the same byte held until the stall clears. Each extra rise re-presents that byte. If the stall lasts TIMEOUT_CYC cycles, the load aborts with code 2.
- R6: After write-enable falls, the clock toggles with select low until the configured input is high. The load then ends with code 0. If that does not happen within TIMEOUT_CYC cycles, the load aborts with code 3.
- R7: An abort drives `tgt_rst` high for exactly PULSE_CYC cycles, with select and write-enable low, and then returns to idle.
- R8: A readback keeps write-enable and data-drive low and gives exactly one rise per byte with select high. After each rise it returns the value on `tgt_din` with a one-cycle `out_valid` pulse.
- R9: After readback select falls, exactly one more low-then-high clock pulse follows.
- R10: `xfer_count` ends equal to the number of bytes clocked over the link. A zero-length load completes with code 0 and no data rises.
- R11: A command offered while `tgt_stall` is high in idle is dropped and starts nothing.
- R12: A load byte is taken from the stream only in a cycle where `in_valid` and `in_ready` are both high. Exactly the commanded number of bytes is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken in idle |
| cmd_read | input | 1 | 1 = readback, 0 = load |
| cmd_len | input | LEN_W | Byte count of the command |
| in_data | input | DATA_W | Load byte stream data |
| in_valid | input | 1 | Load byte available |
| in_ready | output | 1 | Load byte accepted this cycle when valid |
| out_data | output | DATA_W | Readback byte |
| out_valid | output | 1 | One-cycle strobe for out_data |
| tgt_rst | output | 1 | Program (reset) request to the target |
| tgt_sel | output | 1 | Target select |
| tgt_wen | output | 1 | Write-enable, low means read direction |
| tgt_cclk | output | 1 | Configuration clock |
| tgt_dout | output | DATA_W | Data toward the target |
| tgt_doe | output | 1 | Output enable for tgt_dout |
| tgt_din | input | DATA_W | Data from the target |
| tgt_rdy | input | 1 | Target ready (init released) |
| tgt_stall | input | 1 | Target stall |
| tgt_cfgd | input | 1 | Target configured |
| st_busy | output | 1 | Command in progress |
| st_code | output | 2 | Result code of last command |
| xfer_count | output | LEN_W | Bytes clocked in the current or last command |

## Verification
The hardest case to reach is a stall that arrives in the middle of a load. Only a target that reacts to particular clock edges can produce it. The bench models the target at the falling system edge: it records each byte on a rise, and after a chosen byte index it raises stall for a chosen number of extra rises. It sweeps every stall position in each of several load lengths, alongside varied ready delays and configured-clock counts. The three timeouts are reached by giving the model a ready delay, a stall length or a configured-clock count far past TIMEOUT_CYC.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  typedef enum logic [4:0] {
    S_IDLE, S_PROG, S_WAIT, S_WEN, S_FETCH, S_RISE, S_POST, S_STR,
    S_CSOFF, S_WOFF, S_DLO, S_DHI, S_ABORT,
    S_RSEL, S_RHI, S_RCAP, S_RPLO, S_RPHI
  } pcfg_state_t;

  typedef enum logic [1:0] {
    PC_OK       = 2'd0,
    PC_TO_READY = 2'd1,
    PC_TO_STALL = 2'd2,
    PC_TO_CFGD  = 2'd3
  } pcfg_code_t;

endpackage

// File: rtl/pcfg_timer.sv
module pcfg_timer #(
  parameter int LIMIT = 16
)(
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q == LAST);

  // the window count saturates and never passes its limit (R2, R5, R6)
  assert_timer_sat_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

endmodule

// File: rtl/pcfg_loader.sv
module pcfg_loader
  import pcfg_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int LEN_W       = 16,
  parameter int PULSE_CYC   = 20,
  parameter int TIMEOUT_CYC = 2000000,
  parameter bit BUSY_CHECK  = 1'b0
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_read,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              tgt_rst,
  output logic              tgt_sel,
  output logic              tgt_wen,
  output logic              tgt_cclk,
  output logic [DATA_W-1:0] tgt_dout,
  output logic              tgt_doe,
  input  logic [DATA_W-1:0] tgt_din,
  input  logic              tgt_rdy,
  input  logic              tgt_stall,
  input  logic              tgt_cfgd,
  output logic              st_busy,
  output logic [1:0]        st_code,
  output logic [LEN_W-1:0]  xfer_count
);

  pcfg_state_t       state_q;
  pcfg_code_t        code_q, abort_code;
  logic              rst_q, sel_q, wen_q, cclk_q, doe_q, rv_q, abort_go;
  logic [DATA_W-1:0] dout_q, rd_q;
  logic [LEN_W-1:0]  len_q, cnt_q, cnt_inc;
  logic              pulse_run, pulse_exp, long_run, long_exp, stretch_req;

  assign cnt_inc   = cnt_q + 1'b1;
  assign pulse_run = (state_q == S_PROG) || (state_q == S_ABORT);
  assign long_run  = state_q inside {S_WAIT, S_POST, S_STR, S_DLO, S_DHI};

  pcfg_timer #(.LIMIT(PULSE_CYC)) u_pulse (
    .clk(clk), .rst(rst), .run(pulse_run), .expired(pulse_exp));

  pcfg_timer #(.LIMIT(TIMEOUT_CYC)) u_wait (
    .clk(clk), .rst(rst), .run(long_run), .expired(long_exp));

  generate
    if (BUSY_CHECK) begin : g_stretch
      assign stretch_req = tgt_stall;
    end else begin : g_free
      assign stretch_req = 1'b0;
    end
  endgenerate

  always_comb begin
    abort_go   = 1'b0;
    abort_code = PC_OK;
    if (state_q == S_WAIT && !(tgt_rdy && !tgt_stall) && long_exp) begin
      abort_go = 1'b1; abort_code = PC_TO_READY;
    end
    if (state_q == S_POST && stretch_req && long_exp) begin
      abort_go = 1'b1; abort_code = PC_TO_STALL;
    end
    if (state_q == S_DLO && !tgt_cfgd && long_exp) begin
      abort_go = 1'b1; abort_code = PC_TO_CFGD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      rst_q   <= 1'b0;
      sel_q   <= 1'b0;
      wen_q   <= 1'b0;
      cclk_q  <= 1'b1;
      doe_q   <= 1'b0;
      dout_q  <= '0;
      rd_q    <= '0;
      rv_q    <= 1'b0;
      len_q   <= '0;
      cnt_q   <= '0;
      code_q  <= PC_OK;
    end else begin
      rv_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (cmd_valid && !tgt_stall) begin
          len_q  <= cmd_len;
          cnt_q  <= '0;
          code_q <= PC_OK;
          if (cmd_read) begin sel_q <= 1'b1; state_q <= S_RSEL; end
          else begin rst_q <= 1'b1; state_q <= S_PROG; end
        end
        S_PROG: if (pulse_exp) begin rst_q <= 1'b0; state_q <= S_WAIT; end
        S_WAIT: if (tgt_rdy && !tgt_stall) begin wen_q <= 1'b1; state_q <= S_WEN; end
        S_WEN: begin
          sel_q   <= 1'b1;
          doe_q   <= 1'b1;
          state_q <= (len_q == '0) ? S_CSOFF : S_FETCH;
        end
        S_FETCH: if (in_valid) begin
          dout_q  <= in_data;
          cclk_q  <= 1'b0;
          state_q <= S_RISE;
        end
        S_RISE: begin cclk_q <= 1'b1; cnt_q <= cnt_inc; state_q <= S_POST; end
        S_POST:
          if (stretch_req) begin
            if (!long_exp) begin cclk_q <= 1'b0; state_q <= S_STR; end
          end else begin
            state_q <= (cnt_q == len_q) ? S_CSOFF : S_FETCH;
          end
        S_STR:   begin cclk_q <= 1'b1; state_q <= S_POST; end
        S_CSOFF: begin sel_q <= 1'b0; doe_q <= 1'b0; state_q <= S_WOFF; end
        S_WOFF:  begin wen_q <= 1'b0; state_q <= S_DLO; end
        S_DLO:
          if (tgt_cfgd) state_q <= S_IDLE;
          else begin cclk_q <= 1'b0; state_q <= S_DHI; end
        S_DHI:   begin cclk_q <= 1'b1; state_q <= S_DLO; end
        S_ABORT: if (pulse_exp) begin rst_q <= 1'b0; state_q <= S_IDLE; end
        S_RSEL:
          if (len_q == '0) begin sel_q <= 1'b0; state_q <= S_RPLO; end
          else begin cclk_q <= 1'b0; state_q <= S_RHI; end
        S_RHI:   begin cclk_q <= 1'b1; state_q <= S_RCAP; end
        S_RCAP: begin
          rd_q  <= tgt_din;
          rv_q  <= 1'b1;
          cnt_q <= cnt_inc;
          if (cnt_inc == len_q) begin sel_q <= 1'b0; state_q <= S_RPLO; end
          else begin cclk_q <= 1'b0; state_q <= S_RHI; end
        end
        S_RPLO:  begin cclk_q <= 1'b0; state_q <= S_RPHI; end
        S_RPHI:  begin cclk_q <= 1'b1; state_q <= S_IDLE; end
        default: state_q <= S_IDLE;
      endcase
      if (abort_go) begin
        rst_q   <= 1'b1;
        sel_q   <= 1'b0;
        wen_q   <= 1'b0;
        doe_q   <= 1'b0;
        cclk_q  <= 1'b1;
        code_q  <= abort_code;
        state_q <= S_ABORT;
      end
    end
  end

  assign in_ready   = (state_q == S_FETCH);
  assign out_data   = rd_q;
  assign out_valid  = rv_q;
  assign tgt_rst    = rst_q;
  assign tgt_sel    = sel_q;
  assign tgt_wen    = wen_q;
  assign tgt_cclk   = cclk_q;
  assign tgt_dout   = dout_q;
  assign tgt_doe    = doe_q;
  assign st_busy    = (state_q != S_IDLE);
  assign st_code    = code_q;
  assign xfer_count = cnt_q;

  // data driven only while the link is selected for writing (R3)
  assert_drive_needs_write_R3: assert property (@(posedge clk) disable iff (rst)
    tgt_doe |-> (tgt_wen && tgt_sel));

  // select may rise during a load only after write-enable is already up (R3)
  assert_wen_before_sel_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(tgt_sel) && tgt_wen) |-> $past(tgt_wen));

  // write-enable drops only once select is gone (R3)
  assert_sel_before_wen_drop_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(tgt_wen) |-> !tgt_sel);

  // a driven byte never changes on the rising clock edge (R4)
  assert_byte_stable_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(tgt_cclk) && tgt_doe) |-> $stable(tgt_dout));

  // program request never overlaps an open link (R7)
  assert_prog_alone_R7: assert property (@(posedge clk) disable iff (rst)
    tgt_rst |-> (!tgt_sel && !tgt_wen));

  // the transfer count never passes the commanded length (R10)
  assert_count_bound_R10: assert property (@(posedge clk) disable iff (rst)
    xfer_count <= len_q);

endmodule

// File: tb/pcfg_loader_tb.sv
module pcfg_loader_tb;
  localparam int DW = 8;
  localparam int LW = 8;
  localparam int PULSE = 3;
  localparam int TMO = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_read = 1'b0;
  logic [LW-1:0] cmd_len = '0;
  logic [DW-1:0] in_data, out_data, tgt_dout, tgt_din;
  logic in_valid, in_ready, out_valid;
  logic tgt_rst, tgt_sel, tgt_wen, tgt_cclk, tgt_doe, tgt_rdy, tgt_stall, tgt_cfgd;
  logic st_busy;
  logic [1:0] st_code;
  logic [LW-1:0] xfer_count;

  always #2.5 clk = ~clk;

  pcfg_loader #(.DATA_W(DW), .LEN_W(LW), .PULSE_CYC(PULSE),
                .TIMEOUT_CYC(TMO), .BUSY_CHECK(1'b1)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
    .cmd_len(cmd_len), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .tgt_rst(tgt_rst), .tgt_sel(tgt_sel), .tgt_wen(tgt_wen),
    .tgt_cclk(tgt_cclk), .tgt_dout(tgt_dout), .tgt_doe(tgt_doe),
    .tgt_din(tgt_din), .tgt_rdy(tgt_rdy), .tgt_stall(tgt_stall),
    .tgt_cfgd(tgt_cfgd), .st_busy(st_busy), .st_code(st_code),
    .xfer_count(xfer_count));

  int checks = 0, failures = 0;

  // model configuration (written by the stimulus only)
  int init_delay = 0, busy_at = -1, busy_len = 0, done_need = 0, src_len = 0, seed = 0;
  bit force_busy = 1'b0, mdl_reset = 1'b0;

  // target model state (written by the model only)
  bit init_q = 1'b0, busy_q = 1'b0, done_q = 1'b0, saw_cs = 1'b0;
  bit prev_clk = 1'b1, prev_sel = 1'b0, prev_wen = 1'b0, prev_rst = 1'b0;
  int init_ctr = 0, busy_left = 0, post_rises = 0, cap_n = 0, hold_err = 0;
  int stretch_rises = 0, rb_idx = 0, rb_rises = 0, close_rises = 0, ord_err = 0;
  int rdy_err = 0, prog_run = 0, prog_len = 0, prog_pulses = 0, rb_n = 0, src_idx = 0;
  int gap = 0;
  logic [7:0] held = '0;
  logic [7:0] cap [0:63];
  logic [7:0] rb_got [0:63];
  bit acc_q = 1'b0;

  assign tgt_rdy   = init_q;
  assign tgt_stall = busy_q | force_busy;
  assign tgt_cfgd  = done_q;
  assign tgt_din   = 8'(rb_idx * 29 + 11);

  always @(posedge clk) acc_q <= in_valid && in_ready;

  always @(negedge clk) begin
    bit rise;
    rise = tgt_cclk && !prev_clk;
    if (mdl_reset) begin
      cap_n = 0; hold_err = 0; stretch_rises = 0; post_rises = 0; rb_idx = 0;
      rb_rises = 0; close_rises = 0; ord_err = 0; rdy_err = 0; rb_n = 0;
      src_idx = 0; prog_pulses = 0;
    end else begin
      if (acc_q) src_idx++;
      // ordering observations, on values the design acted on
      if (tgt_sel && !prev_sel && tgt_wen && !prev_wen) ord_err++;
      if (!tgt_wen && prev_wen && tgt_sel) ord_err++;
      if (tgt_doe && !(tgt_sel && tgt_wen)) ord_err++;
      if (tgt_rst && (tgt_sel || tgt_wen)) ord_err++;
      if (tgt_wen && !prev_wen && (!init_q || force_busy)) rdy_err++;
      if (out_valid) begin rb_got[rb_n] = out_data; rb_n++; end
      // program pulse tracking
      if (tgt_rst) begin
        prog_run = prev_rst ? prog_run + 1 : 1;
        if (!prev_rst) prog_pulses++;
        init_q = 1'b0; done_q = 1'b0; busy_q = 1'b0; init_ctr = 0;
        saw_cs = 1'b0; post_rises = 0;
      end else begin
        if (prev_rst) prog_len = prog_run;
        if (!init_q) begin
          if (init_ctr >= init_delay) init_q = 1'b1; else init_ctr++;
        end
      end
      if (tgt_sel) saw_cs = 1'b1;
      if (rise && tgt_sel && tgt_wen) begin
        if (!tgt_doe) ord_err++;
        if (busy_q) begin
          if (tgt_dout !== held) hold_err++;
          stretch_rises++;
          busy_left--;
          if (busy_left <= 0) busy_q = 1'b0;
        end else begin
          cap[cap_n] = tgt_dout;
          held = tgt_dout;
          if (cap_n == busy_at) begin busy_q = 1'b1; busy_left = busy_len; end
          cap_n++;
        end
      end
      if (rise && tgt_sel && !tgt_wen) begin rb_rises++; rb_idx++; end
      if (rise && !tgt_sel) close_rises++;
      if (rise && !tgt_sel && !tgt_wen && saw_cs) post_rises++;
      if (saw_cs && !tgt_sel && !tgt_wen && post_rises >= done_need) done_q = 1'b1;
    end
    prev_clk = tgt_cclk; prev_sel = tgt_sel; prev_wen = tgt_wen; prev_rst = tgt_rst;
    gap++;
    in_valid = (src_idx < src_len) && (gap % 3 != 2);
    in_data  = 8'(src_idx * 13 + seed * 7 + 5);
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic clear_model();
    mdl_reset = 1'b1; step(); mdl_reset = 1'b0;
  endtask

  task automatic issue(bit rd, int len);
    step();
    cmd_valid = 1'b1; cmd_read = rd; cmd_len = LW'(len);
    step();
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (st_busy) step();
  endtask

  task automatic do_load(int len, int bat, int blen, int idly, int dneed, int sd);
    init_delay = idly; busy_at = bat; busy_len = blen; done_need = dneed;
    src_len = len; seed = sd;
    clear_model();
    issue(1'b0, len);
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) step();
    // R1 reset state
    chk("R1 prog", tgt_rst, 0); chk("R1 sel", tgt_sel, 0); chk("R1 wen", tgt_wen, 0);
    chk("R1 cclk", tgt_cclk, 1); chk("R1 doe", tgt_doe, 0); chk("R1 busy", st_busy, 0);
    chk("R1 code", st_code, 0); chk("R1 count", xfer_count, 0);
    rst = 1'b0;
    repeat (3) step();

    // R11 command dropped while the target stalls
    clear_model();
    force_busy = 1'b1;
    issue(1'b0, 3);
    repeat (5) step();
    chk("R11 not started", st_busy, 0);
    chk("R11 no program pulse", prog_pulses, 0);
    force_busy = 1'b0;

    // load sweep: every stall position for each length
    for (int len = 1; len <= 6; len++) begin
      for (int b = -1; b < len; b++) begin
        int bl;
        int bad;
        bl = (b < 0) ? 0 : 1 + (len + b) % 3;
        do_load(len, b, bl, len, len % 3, len * 8 + b);
        chk("R6 code ok", st_code, 0);
        chk("R10 count", xfer_count, len);
        chk("R4 bytes seen", cap_n, len);
        bad = 0;
        for (int i = 0; i < len; i++)
          if (cap[i] !== 8'(i * 13 + (len * 8 + b) * 7 + 5)) bad++;
        chk("R4 byte values", bad, 0);
        chk("R5 hold during stall", hold_err, 0);
        chk("R5 stall rises", stretch_rises, bl);
        chk("R6 configured rises", post_rises, len % 3);
        chk("R3 ordering", ord_err, 0);
        chk("R2 pulse width", prog_len, PULSE);
        chk("R2 ready gate", rdy_err, 0);
        chk("R12 consumed", src_idx, len);
      end
    end

    // R2 stall held during the ready wait
    init_delay = 2; busy_at = -1; done_need = 0; src_len = 2; seed = 3;
    clear_model();
    issue(1'b0, 2);
    force_busy = 1'b1;
    repeat (20) step();
    chk("R2 waits on stall", tgt_wen, 0);
    force_busy = 1'b0;
    wait_idle();
    chk("R2 ready gate stall", rdy_err, 0);
    chk("R2 code after stall", st_code, 0);

    // R10 zero length load
    do_load(0, -1, 0, 1, 0, 9);
    chk("R10 zero code", st_code, 0);
    chk("R10 zero count", xfer_count, 0);
    chk("R10 zero rises", cap_n, 0);
    chk("R3 zero ordering", ord_err, 0);

    // readback sweep
    for (int len = 1; len <= 7; len++) begin
      int bad;
      clear_model();
      issue(1'b1, len);
      wait_idle();
      chk("R8 code", st_code, 0);
      chk("R8 strobes", rb_n, len);
      bad = 0;
      for (int k = 0; k < len; k++)
        if (rb_got[k] !== 8'((k + 1) * 29 + 11)) bad++;
      chk("R8 values", bad, 0);
      chk("R8 rises", rb_rises, len);
      chk("R9 closing pulse", close_rises, 1);
      chk("R10 read count", xfer_count, len);
      chk("R8 no drive", ord_err, 0);
      chk("R8 no program", prog_pulses, 0);
    end

    // timeouts and aborts
    do_load(3, -1, 0, 1000, 0, 1);
    chk("R2 ready timeout code", st_code, 1);
    chk("R7 abort pulse width", prog_len, PULSE);
    chk("R7 two pulses", prog_pulses, 2);
    chk("R7 sel low", tgt_sel, 0);
    chk("R7 wen low", tgt_wen, 0);
    chk("R10 count at ready abort", xfer_count, 0);

    do_load(5, 2, 1000, 1, 0, 2);
    chk("R5 stall timeout code", st_code, 2);
    chk("R10 count at stall abort", xfer_count, 3);
    chk("R7 abort pulse width stall", prog_len, PULSE);
    chk("R3 ordering at stall abort", ord_err, 0);

    do_load(4, -1, 0, 1, 1000, 4);
    chk("R6 configured timeout code", st_code, 3);
    chk("R10 count at configured abort", xfer_count, 4);
    chk("R7 two pulses configured", prog_pulses, 2);

    // recovery after an abort
    do_load(2, -1, 0, 0, 0, 5);
    chk("R7 recovers", st_code, 0);
    chk("R4 bytes after abort", cap_n, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule